// File: doc/BRIEF.md
# Interleaved Transmit Sample Capture and De-interleave

This block sits between a host that streams transmit samples over one narrow parallel bus and the digital transmit path. The host changes the bus once per edge of an interface clock. The block samples the bus on the rising edge, on the falling edge, or on both edges, as the run-time configuration selects. In dual-channel operation, in-phase (I) and quadrature (Q) samples share the bus in time. The block separates them and presents each pair on two output words with a one-cycle valid strobe. A configuration bit picks which channel comes first in each pair. In single-channel operation, each captured word goes straight to the I output.

Pairing uses an explicit phase toggle. Any change to the capture or pairing configuration sends the toggle back to the first-of-pair phase. A retime option sends completed pairs through a two-slot handoff into a second, faster clock domain, so that a pair is never split. The block also reports how many converter updates each input word stands for under the selected interpolation setting.

The output has no back-pressure. The downstream logic must accept every strobe, because pairs cannot be stalled. The host bus has no qualifier, so every enabled edge carries a word.

Top module: `txcap_deint`

## Requirements
- R1: While rst_n is low, out_valid and rt_valid are 0 and out_i/out_q are 0. The first if_clk rising edge after reset release produces no strobe.
- R2: With cfg_two_edge=0, cfg_edge_inv=0 captures the word present at each rising edge of if_clk, and cfg_edge_inv=1 captures the word present at each falling edge.
- R3: Single-channel (cfg_dual=0) with one capture edge asserts out_valid on every cycle, with out_i = the captured word and out_q = 0.
- R4: With cfg_two_edge=1, cfg_edge_inv is ignored. The rising-edge word is the first word of a cycle and the following falling-edge word is the second. Each cycle gives one strobe. In single-channel mode, out_i = first and out_q = second.
- R5: Dual-channel (cfg_dual=1) with one capture edge treats successive words alternately as first and second of a pair. It asserts out_valid for exactly one cycle after each second word, with both words of the pair presented together.
- R6: In dual-channel mode, cfg_q_first=0 makes the first word of a pair I and the second Q. cfg_q_first=1 makes the first word Q and the second I.
- R7: When cfg_edge_inv, cfg_two_edge, cfg_dual or cfg_q_first differs at a rising edge from its value at the previous rising edge, the word processed at that edge is the first word of a new pair and no strobe results.
- R8: The words of cycle k (rising edge k and the falling edge after it) are reported after rising edge k+1.
- R9: With cfg_retime=1, out_valid stays 0. Pairs instead appear in order on rt_i/rt_q with rt_valid high for one alt_clk cycle per pair. Both words of a pair are given together, and no pair is lost while alt_clk runs at least twice as fast as if_clk.
- R10: upd_per_word reports 1, 2, 4, 1 for cfg_interp = 00, 01, 10, 11.
- R11: The cfg_retime value at the rising edge that completes a pair decides which output the pair goes to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| if_clk | input | 1 | Interface clock that times the host bus |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| alt_clk | input | 1 | Destination clock for the retime path |
| tx_bus | input | 14 | Shared transmit sample bus |
| cfg_edge_inv | input | 1 | Single-edge capture on the falling edge when 1 |
| cfg_two_edge | input | 1 | Capture on both edges when 1 |
| cfg_dual | input | 1 | Dual-channel interleaved operation when 1 |
| cfg_q_first | input | 1 | Q word leads each pair when 1 |
| cfg_retime | input | 1 | Route pairs to the alt_clk domain when 1 |
| cfg_interp | input | 2 | Interpolation setting |
| out_valid | output | 1 | One-cycle strobe for a pair in the if_clk domain |
| out_i | output | 14 | I word (if_clk domain) |
| out_q | output | 14 | Q word, or second word in single-channel two-edge mode |
| rt_valid | output | 1 | One-cycle strobe for a pair in the alt_clk domain |
| rt_i | output | 14 | Retimed I word |
| rt_q | output | 14 | Retimed Q word |
| upd_per_word | output | 3 | Converter updates per input word |

## Verification
Two functions can land on the same edge: a configuration change, and the edge that would complete a pair (or that switches the retime route). The bench provokes this by changing the channel order or capture edge after an odd number of dual-channel words. It also toggles cfg_retime while pairs are being completed. A behavioural queue model is checked on every if_clk cycle: the stranded first word must be dropped, no strobe may appear at the change, and pairing must restart with the next word. Each retimed pair must come out of the alt_clk side in order.

// File: rtl/txcap_pkg.sv
package txcap_pkg;

  typedef enum logic [1:0] {
    INTERP_OFF  = 2'b00,
    INTERP_X2   = 2'b01,
    INTERP_X4   = 2'b10,
    INTERP_RSVD = 2'b11
  } interp_e;

  typedef struct packed {
    logic edge_inv;
    logic two_edge;
    logic dual;
    logic q_first;
  } capcfg_t;

  function automatic logic [2:0] interp_ratio(input interp_e sel);
    logic [2:0] r;
    case (sel)
      INTERP_X2: r = 3'd2;
      INTERP_X4: r = 3'd4;
      default:   r = 3'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/txcap_edge_capture.sv
module txcap_edge_capture #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus,
  output logic [W-1:0] rise_word,
  output logic [W-1:0] fall_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_word <= '0;
    else        rise_word <= bus;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_word <= '0;
    else        fall_word <= bus;
  end

endmodule

// File: rtl/txcap_pair_builder.sv
module txcap_pair_builder
  import txcap_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise_word,
  input  logic [W-1:0] fall_word,
  input  capcfg_t      cfg,
  input  logic         retime,
  output logic         out_valid,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q,
  output logic         wr_en,
  output logic [W-1:0] wr_i,
  output logic [W-1:0] wr_q
);

  logic         primed;
  logic         phase;
  capcfg_t      cfg_q;
  logic [W-1:0] hold;

  logic         cfg_moved;
  logic         phase_eff;
  logic         split_mode;
  logic [W-1:0] sel_word;
  logic         emit;
  logic [W-1:0] nxt_i;
  logic [W-1:0] nxt_q;

  assign cfg_moved  = (cfg != cfg_q);
  assign phase_eff  = cfg_moved ? 1'b0 : phase;
  assign split_mode = cfg.dual && !cfg.two_edge;
  assign sel_word   = cfg.edge_inv ? fall_word : rise_word;

  always_comb begin
    emit  = 1'b0;
    nxt_i = '0;
    nxt_q = '0;
    if (cfg.two_edge) begin
      emit = 1'b1;
      if (cfg.dual && cfg.q_first) begin
        nxt_i = fall_word;
        nxt_q = rise_word;
      end else begin
        nxt_i = rise_word;
        nxt_q = fall_word;
      end
    end else if (!cfg.dual) begin
      emit  = 1'b1;
      nxt_i = sel_word;
    end else begin
      emit = phase_eff;
      if (cfg.q_first) begin
        nxt_i = sel_word;
        nxt_q = hold;
      end else begin
        nxt_i = hold;
        nxt_q = sel_word;
      end
    end
    emit = emit && primed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      phase  <= 1'b0;
      cfg_q  <= '0;
      hold   <= '0;
    end else begin
      primed <= 1'b1;
      cfg_q  <= cfg;
      if (primed && split_mode) begin
        phase <= ~phase_eff;
        if (!phase_eff) hold <= sel_word;
      end else begin
        phase <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= emit && !retime;
      if (emit && !retime) begin
        out_i <= nxt_i;
        out_q <= nxt_q;
      end
    end
  end

  assign wr_en = emit && retime;
  assign wr_i  = nxt_i;
  assign wr_q  = nxt_q;

endmodule

// File: rtl/txcap_retime_handoff.sv
module txcap_retime_handoff #(
  parameter int W           = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_i,
  input  logic [W-1:0] wr_q,
  output logic         rd_valid,
  output logic [W-1:0] rd_i,
  output logic [W-1:0] rd_q
);

  localparam int PW = 2;
  localparam int SW = SYNC_STAGES * PW;

  logic [W-1:0]  slot_i [2];
  logic [W-1:0]  slot_q [2];
  logic [PW-1:0] wbin;
  logic [PW-1:0] wgray;
  logic [PW-1:0] wbin_nxt;
  logic [SW-1:0] chain;
  logic [PW-1:0] rgray;
  logic [PW-1:0] rseen;
  logic [PW-1:0] rbin;

  assign wbin_nxt = wbin + 2'd1;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ {1'b0, wbin_nxt[1]};
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en) begin
      slot_i[wbin[0]] <= wr_i;
      slot_q[wbin[0]] <= wr_q;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= wgray;
      end
    end else begin : g_many
      always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SW-PW-1:0], wgray};
      end
    end
  endgenerate

  assign rgray = chain[SW-1 -: PW];
  assign rseen = {rgray[1], rgray[1] ^ rgray[0]};

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rd_valid <= 1'b0;
      rd_i     <= '0;
      rd_q     <= '0;
    end else if (rseen != rbin) begin
      rbin     <= rbin + 2'd1;
      rd_valid <= 1'b1;
      rd_i     <= slot_i[rbin[0]];
      rd_q     <= slot_q[rbin[0]];
    end else begin
      rd_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/txcap_deint.sv
module txcap_deint
  import txcap_pkg::*;
#(
  parameter int W           = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic         if_clk,
  input  logic         rst_n,
  input  logic         alt_clk,
  input  logic [W-1:0] tx_bus,
  input  logic         cfg_edge_inv,
  input  logic         cfg_two_edge,
  input  logic         cfg_dual,
  input  logic         cfg_q_first,
  input  logic         cfg_retime,
  input  logic [1:0]   cfg_interp,
  output logic         out_valid,
  output logic [W-1:0] out_i,
  output logic [W-1:0] out_q,
  output logic         rt_valid,
  output logic [W-1:0] rt_i,
  output logic [W-1:0] rt_q,
  output logic [2:0]   upd_per_word
);

  capcfg_t      cfg;
  logic [W-1:0] rise_word;
  logic [W-1:0] fall_word;
  logic         wr_en;
  logic [W-1:0] wr_i;
  logic [W-1:0] wr_q;

  assign cfg.edge_inv = cfg_edge_inv;
  assign cfg.two_edge = cfg_two_edge;
  assign cfg.dual     = cfg_dual;
  assign cfg.q_first  = cfg_q_first;

  assign upd_per_word = interp_ratio(interp_e'(cfg_interp));

  txcap_edge_capture #(.W(W)) u_cap (
    .clk       (if_clk),
    .rst_n     (rst_n),
    .bus       (tx_bus),
    .rise_word (rise_word),
    .fall_word (fall_word)
  );

  txcap_pair_builder #(.W(W)) u_pair (
    .clk       (if_clk),
    .rst_n     (rst_n),
    .rise_word (rise_word),
    .fall_word (fall_word),
    .cfg       (cfg),
    .retime    (cfg_retime),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .wr_en     (wr_en),
    .wr_i      (wr_i),
    .wr_q      (wr_q)
  );

  txcap_retime_handoff #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_rt (
    .wclk     (if_clk),
    .rclk     (alt_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_i     (wr_i),
    .wr_q     (wr_q),
    .rd_valid (rt_valid),
    .rd_i     (rt_i),
    .rd_q     (rt_q)
  );

endmodule

// File: rtl/txcap_deint_chk.sv
module txcap_deint_chk #(
  parameter int W = 14
) (
  input logic         if_clk,
  input logic         rst_n,
  input logic         cfg_edge_inv,
  input logic         cfg_two_edge,
  input logic         cfg_dual,
  input logic         cfg_q_first,
  input logic         cfg_retime,
  input logic         out_valid,
  input logic [W-1:0] out_q,
  input logic [2:0]   upd_per_word
);

  logic       armed;
  logic [3:0] cfgv;
  logic       split_now;

  assign cfgv      = {cfg_edge_inv, cfg_two_edge, cfg_dual, cfg_q_first};
  assign split_now = cfg_dual && !cfg_two_edge && !cfg_retime;

  always_ff @(posedge if_clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_RETIME_MUTES_DIRECT: assert property (@(posedge if_clk) disable iff (!rst_n)
    cfg_retime |=> !out_valid); // R9

  AST_DUAL_STROBE_SPACED: assert property (@(posedge if_clk) disable iff (!rst_n)
    (out_valid && split_now) |=> !out_valid); // R5

  AST_CFG_CHANGE_NO_STROBE: assert property (@(posedge if_clk) disable iff (!rst_n)
    (armed && split_now && (cfgv != $past(cfgv))) |=> !out_valid); // R7

  AST_STREAM_EVERY_CYCLE: assert property (@(posedge if_clk) disable iff (!rst_n)
    (armed && !cfg_retime && !(cfg_dual && !cfg_two_edge)) |=> out_valid); // R3

  AST_SINGLE_Q_ZERO: assert property (@(posedge if_clk) disable iff (!rst_n)
    (!cfg_dual && !cfg_two_edge && !cfg_retime) |=> (!out_valid || out_q == '0)); // R3

  AST_RATE_ONEHOT: assert property (@(posedge if_clk) disable iff (!rst_n)
    $countones(upd_per_word) == 1); // R10

endmodule

bind txcap_deint txcap_deint_chk #(.W(W)) u_chk (
  .if_clk       (if_clk),
  .rst_n        (rst_n),
  .cfg_edge_inv (cfg_edge_inv),
  .cfg_two_edge (cfg_two_edge),
  .cfg_dual     (cfg_dual),
  .cfg_q_first  (cfg_q_first),
  .cfg_retime   (cfg_retime),
  .out_valid    (out_valid),
  .out_q        (out_q),
  .upd_per_word (upd_per_word)
);

// File: tb/sim_txcap_deint.sv
module sim_txcap_deint;
  timeunit 1ns;
  timeprecision 1ns;

  localparam int W       = 14;
  localparam int CLK_PER = 20;
  localparam int ALT_PER = 8;
  localparam int Q       = CLK_PER / 4;

  logic         if_clk = 1'b0;
  logic         alt_clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] tx_bus = '0;
  logic         cfg_edge_inv = 1'b0;
  logic         cfg_two_edge = 1'b0;
  logic         cfg_dual = 1'b0;
  logic         cfg_q_first = 1'b0;
  logic         cfg_retime = 1'b0;
  logic [1:0]   cfg_interp = 2'b00;
  logic         out_valid;
  logic [W-1:0] out_i;
  logic [W-1:0] out_q;
  logic         rt_valid;
  logic [W-1:0] rt_i;
  logic [W-1:0] rt_q;
  logic [2:0]   upd_per_word;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;

  always #(CLK_PER/2) if_clk = ~if_clk;
  always #(ALT_PER/2) alt_clk = ~alt_clk;

  txcap_deint #(.W(W)) u0 (
    .if_clk(if_clk), .rst_n(rst_n), .alt_clk(alt_clk), .tx_bus(tx_bus),
    .cfg_edge_inv(cfg_edge_inv), .cfg_two_edge(cfg_two_edge), .cfg_dual(cfg_dual),
    .cfg_q_first(cfg_q_first), .cfg_retime(cfg_retime), .cfg_interp(cfg_interp),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
    .rt_valid(rt_valid), .rt_i(rt_i), .rt_q(rt_q), .upd_per_word(upd_per_word)
  );

  // Behavioural reference model
  logic [W-1:0]   m_rise = '0;
  logic [W-1:0]   m_fall = '0;
  logic [W-1:0]   pend[$];
  logic [2*W-1:0] rq[$];
  bit             m_primed = 1'b0;
  logic [3:0]     m_prev = '0;
  bit             e_valid = 1'b0;
  logic [W-1:0]   e_i = '0;
  logic [W-1:0]   e_q = '0;
  string          e_tag = "R1";

  always @(negedge if_clk) m_fall = tx_bus;

  always @(posedge if_clk) begin
    if (!rst_n) begin
      m_primed = 1'b0;
      m_prev   = '0;
      pend.delete();
      e_valid  = 1'b0;
      e_tag    = "R1";
    end else begin
      logic [3:0]   now;
      bit           emit;
      logic [W-1:0] a;
      logic [W-1:0] b;
      now     = {cfg_edge_inv, cfg_two_edge, cfg_dual, cfg_q_first};
      emit    = 1'b0;
      a       = '0;
      b       = '0;
      e_valid = 1'b0;
      if (!m_primed) begin
        e_tag = "R1";
      end else if (cfg_two_edge) begin
        pend.delete();
        emit  = 1'b1;
        e_tag = cfg_dual ? "R4/R6" : "R4";
        if (cfg_dual && cfg_q_first) begin a = m_fall; b = m_rise; end
        else begin a = m_rise; b = m_fall; end
      end else if (!cfg_dual) begin
        pend.delete();
        emit  = 1'b1;
        e_tag = "R2/R3";
        a     = cfg_edge_inv ? m_fall : m_rise;
      end else begin
        e_tag = "R5/R6";
        if (now != m_prev) begin
          pend.delete();
          e_tag = "R7";
        end
        pend.push_back(cfg_edge_inv ? m_fall : m_rise);
        if (pend.size() == 2) begin
          emit = 1'b1;
          if (cfg_q_first) begin a = pend[1]; b = pend[0]; end
          else begin a = pend[0]; b = pend[1]; end
          pend.delete();
        end
      end
      if (emit) begin
        // R11: route chosen by cfg_retime at the completing edge
        if (cfg_retime) rq.push_back({a, b});
        else begin e_valid = 1'b1; e_i = a; e_q = b; end
      end
      m_primed = 1'b1;
      m_prev   = now;
      m_rise   = tx_bus;
    end
  end

  // Direct-side comparison every cycle (R8 latency implied)
  always @(posedge if_clk) begin
    #(Q);
    if (chk_on) begin
      n_chk++;
      if (out_valid !== e_valid) begin
        n_fail++;
        $display("FAIL %s/R8 out_valid actual=%0b expected=%0b", e_tag, out_valid, e_valid);
      end else if (e_valid && (out_i !== e_i || out_q !== e_q)) begin
        n_fail++;
        $display("FAIL %s/R8 pair actual=%h/%h expected=%h/%h", e_tag, out_i, out_q, e_i, e_q);
      end
    end
  end

  // Retimed-side comparison (R9)
  always @(posedge alt_clk) begin
    #1;
    if (rt_valid) begin
      n_chk++;
      if (rq.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected rt pair actual=%h/%h expected=none", rt_i, rt_q);
      end else begin
        logic [2*W-1:0] exp_p;
        exp_p = rq.pop_front();
        if ({rt_i, rt_q} !== exp_p) begin
          n_fail++;
          $display("FAIL R9 rt pair actual=%h/%h expected=%h/%h",
                   rt_i, rt_q, exp_p[2*W-1:W], exp_p[W-1:0]);
        end
      end
    end
  end

  task automatic run_cycles(input int n);
    repeat (n) begin
      @(posedge if_clk);
      #(Q);
      tx_bus = W'($urandom);
      #(2*Q);
      tx_bus = W'($urandom);
    end
  endtask

  task automatic set_cfg(input bit ei, input bit te, input bit du, input bit qf, input bit rt);
    cfg_edge_inv = ei;
    cfg_two_edge = te;
    cfg_dual     = du;
    cfg_q_first  = qf;
    cfg_retime   = rt;
  endtask

  task automatic check_val(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state with busy bus and non-zero configuration
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    repeat (3) begin
      @(posedge if_clk);
      #(Q);
      tx_bus = W'($urandom);
    end
    check_val("R1 out_valid in reset", int'(out_valid), 0);
    check_val("R1 rt_valid in reset", int'(rt_valid), 0);
    check_val("R1 out_i in reset", int'(out_i), 0);
    check_val("R1 out_q in reset", int'(out_q), 0);
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    @(posedge if_clk);
    #(Q);
    check_val("R1 no strobe at first edge", int'(out_valid), 0);

    // R2/R3: single channel, rising then falling capture
    run_cycles(12);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cycles(12);
    // R4: both edges, single channel, edge_inv ignored
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_cycles(8);
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_cycles(8);
    // R4/R6: both edges, dual, each order
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_cycles(8);
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    run_cycles(8);
    // R5/R6: dual single edge, rising, I first
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_cycles(9);
    // R7: order change after an odd number of words
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_cycles(7);
    // R7: edge change mid-pair, then falling-edge dual
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_cycles(10);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_cycles(5);

    // R9/R11: retime on across modes, toggling while pairs complete
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    run_cycles(11);
    set_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    run_cycles(10);
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_cycles(10);
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cycles(3);
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    run_cycles(6);
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_cycles(6);
    check_val("R9 retime queue drained", rq.size(), 0);

    // R10: rate report
    for (int s = 0; s < 4; s++) begin
      cfg_interp = 2'(s);
      #(Q);
      check_val("R10 upd_per_word", int'(upd_per_word), (s == 1) ? 2 : (s == 2) ? 4 : 1);
    end

    chk_on = 1'b0;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule